// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides a dividend of twice the word width by a one-word divisor. It returns a one-word quotient and a one-word remainder. It works one quotient bit per clock using trial subtraction. A single partial-remainder register holds the running remainder in its upper half. Its lower half holds the dividend bits that have not yet been consumed, and quotient bits fill that lower half from the bottom as the dividend bits leave it. The left shift is part of the register's load path, so each iteration takes exactly one cycle.

A request is a one-cycle `start` pulse carrying the operands and a mode bit. In signed mode the block takes the magnitudes of both operands, divides them, and then spends one more cycle applying the result signs. The remainder comes out on the high-word port and the quotient on the low-word port. Two cases are flagged at once and start no iteration: a zero divisor, and a quotient that would not fit in one word.

Top module: `div_restoring_seq`

## Requirements
- R1: After reset, `busy`, `done`, `overflow` and `div_zero` are 0, and `quo_lo` and `rem_hi` are 0.
- R2: In unsigned mode (`signed_mode`=0), the result satisfies dividend = quotient*divisor + remainder, with remainder < divisor. With K=4, 0x75 / 0xA gives quotient 0xB and remainder 0x7, and 0x0D / 0x5 gives quotient 0x2 and remainder 0x3.
- R3: In signed mode (`signed_mode`=1), operands are two's complement. The quotient is the magnitude quotient, negated exactly when the operand signs differ. The remainder is the magnitude remainder and takes the sign of the dividend. Both are truncated to K bits. Examples: 5/-3 gives -1 r 2, -5/3 gives -1 r -2, and -5/-3 gives 1 r -2.
- R4: A zero divisor sets `div_zero`=1 and `overflow`=0. It returns a quotient of all ones and a remainder equal to the low K bits of the dividend as given.
- R5: If the divisor is nonzero and the upper K bits of the dividend magnitude are greater than or equal to the divisor magnitude, the block sets `overflow`=1. It returns a quotient of all ones and a remainder of 0.
- R6: An accepted unsigned request that is not flagged keeps `busy` high for exactly K cycles. `done` is high in the cycle right after the last busy cycle.
- R7: An accepted signed request that is not flagged keeps `busy` high for K+1 cycles: K iterations plus one sign-correction cycle.
- R8: A flagged request (R4, R5) never raises `busy`. `done` is high in the cycle after `start` is sampled.
- R9: A `start` pulse while `busy` is high is ignored. The running division completes with its original operands.
- R10: `done` lasts exactly one cycle and is never high together with `busy`. The outputs and flags hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken when not busy |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | 2*K | Dividend |
| divisor | input | K | Divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quo_lo | output | K | Quotient (low word) |
| rem_hi | output | K | Remainder (high word) |
| overflow | output | 1 | Quotient did not fit; no iteration ran |
| div_zero | output | 1 | Divisor was zero |

## Verification
The embedded assertions assume that iteration starts only when the remainder half of the partial-remainder register is already below the divisor magnitude. That condition is guaranteed by the overflow screen. They also assume the operands are sampled only in the start cycle, so later changes on the input pins must not matter. The stimulus changes operands and pulses `start` in the middle of runs to test that second assumption. Random operands are drawn with both zero and nonzero divisors in both modes, so that the overflow screen and the divide-by-zero path are hit often. Directed vectors cover the signed sign combinations and the most negative operands.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_prep.sv
module div_prep #(
  parameter int K = 8
) (
  input  logic [2*K-1:0] dvd,
  input  logic [K-1:0]   dvs,
  input  logic           sm,
  output logic [2*K-1:0] dvd_mag,
  output logic [K-1:0]   dvs_mag,
  output logic           neg_q,
  output logic           neg_r,
  output logic           is_zero,
  output logic           is_ovf
);
  localparam int DW = 2 * K;

  function automatic logic [DW-1:0] mag_wide(input logic [DW-1:0] v, input logic s);
    return (s && v[DW-1]) ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [K-1:0] mag_word(input logic [K-1:0] v, input logic s);
    return (s && v[K-1]) ? (~v + 1'b1) : v;
  endfunction

  logic dvd_neg, dvs_neg;

  always_comb begin
    dvd_neg = sm && dvd[DW-1];
    dvs_neg = sm && dvs[K-1];
    dvd_mag = mag_wide(dvd, sm);
    dvs_mag = mag_word(dvs, sm);
    neg_q   = dvd_neg ^ dvs_neg;
    neg_r   = dvd_neg;
    is_zero = (dvs == '0);
    is_ovf  = !is_zero && (dvd_mag[DW-1:K] >= dvs_mag);
  end
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int K = 8
) (
  input  logic [2*K-1:0] pr,
  input  logic [K-1:0]   dvs,
  output logic [2*K-1:0] pr_next,
  output logic           qbit
);
  logic [K:0] top;
  logic [K:0] diff;

  always_comb begin
    top     = pr[2*K-1:K-1];
    diff    = top - {1'b0, dvs};
    qbit    = (top >= {1'b0, dvs});
    pr_next = qbit ? {diff[K-1:0], pr[K-2:0], 1'b1}
                   : {pr[2*K-2:0], 1'b0};
  end
endmodule

// File: rtl/div_fix.sv
module div_fix #(
  parameter int K = 8
) (
  input  logic [K-1:0] q_mag,
  input  logic [K-1:0] r_mag,
  input  logic         neg_q,
  input  logic         neg_r,
  output logic [K-1:0] q_out,
  output logic [K-1:0] r_out
);
  function automatic logic [K-1:0] apply_sign(input logic [K-1:0] v, input logic n);
    return n ? (~v + 1'b1) : v;
  endfunction

  always_comb begin
    q_out = apply_sign(q_mag, neg_q);
    r_out = apply_sign(r_mag, neg_r);
  end
endmodule

// File: rtl/div_restoring_seq.sv
module div_restoring_seq #(
  parameter int K = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           signed_mode,
  input  logic [2*K-1:0] dividend,
  input  logic [K-1:0]   divisor,
  output logic           busy,
  output logic           done,
  output logic [K-1:0]   quo_lo,
  output logic [K-1:0]   rem_hi,
  output logic           overflow,
  output logic           div_zero
);
  import div_pkg::*;

  localparam int DW = 2 * K;
  localparam int CW = $clog2(K + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(K - 1);

  div_state_e     state;
  logic [DW-1:0]  pr;
  logic [K-1:0]   dvs_r;
  logic           sm_r, negq_r, negr_r;
  logic [CW-1:0]  cnt;

  logic [DW-1:0]  dvd_mag;
  logic [K-1:0]   dvs_mag;
  logic           neg_q, neg_r, is_zero, is_ovf;
  logic [DW-1:0]  pr_next;
  logic           qbit;
  logic [K-1:0]   fix_q, fix_r;

  logic           accept;
  logic           iter_last;

  div_prep #(.K(K)) u_prep (
    .dvd(dividend), .dvs(divisor), .sm(signed_mode),
    .dvd_mag(dvd_mag), .dvs_mag(dvs_mag),
    .neg_q(neg_q), .neg_r(neg_r), .is_zero(is_zero), .is_ovf(is_ovf)
  );

  div_step #(.K(K)) u_step (
    .pr(pr), .dvs(dvs_r), .pr_next(pr_next), .qbit(qbit)
  );

  div_fix #(.K(K)) u_fix (
    .q_mag(pr[K-1:0]), .r_mag(pr[DW-1:K]),
    .neg_q(negq_r), .neg_r(negr_r),
    .q_out(fix_q), .r_out(fix_r)
  );

  assign busy      = (state != ST_IDLE);
  assign accept    = (state == ST_IDLE) && start;
  assign iter_last = (state == ST_RUN) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pr       <= '0;
      dvs_r    <= '0;
      sm_r     <= 1'b0;
      negq_r   <= 1'b0;
      negr_r   <= 1'b0;
      cnt      <= '0;
      done     <= 1'b0;
      quo_lo   <= '0;
      rem_hi   <= '0;
      overflow <= 1'b0;
      div_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (is_zero) begin
              quo_lo   <= '1;
              rem_hi   <= dividend[K-1:0];
              div_zero <= 1'b1;
              overflow <= 1'b0;
              done     <= 1'b1;
            end else if (is_ovf) begin
              quo_lo   <= '1;
              rem_hi   <= '0;
              div_zero <= 1'b0;
              overflow <= 1'b1;
              done     <= 1'b1;
            end else begin
              pr     <= dvd_mag;
              dvs_r  <= dvs_mag;
              sm_r   <= signed_mode;
              negq_r <= neg_q;
              negr_r <= neg_r;
              cnt    <= LAST_CNT;
              state  <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          pr  <= pr_next;
          cnt <= cnt - 1'b1;
          if (cnt == '0) begin
            if (sm_r) begin
              state <= ST_FIX;
            end else begin
              quo_lo   <= pr_next[K-1:0];
              rem_hi   <= pr_next[DW-1:K];
              overflow <= 1'b0;
              div_zero <= 1'b0;
              done     <= 1'b1;
              state    <= ST_IDLE;
            end
          end
        end
        ST_FIX: begin
          quo_lo   <= fix_q;
          rem_hi   <= fix_r;
          overflow <= 1'b0;
          div_zero <= 1'b0;
          done     <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  partial_rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (pr[DW-1:K] < dvs_r));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !iter_last && state != ST_FIX) |=> busy);

  // R4
  zero_quot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_zero) |-> (quo_lo == '1 && !overflow));

  // R8
  flag_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (is_zero || is_ovf)) |=> (done && !busy));

  // R7
  fix_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIX) |=> done);
endmodule

// File: tb/div_restoring_seq_test.sv
module div_restoring_seq_test;
  localparam int K  = 4;
  localparam int DW = 2 * K;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          signed_mode = 1'b0;
  logic [DW-1:0] dividend = '0;
  logic [K-1:0]  divisor = '0;
  logic          busy, done, overflow, div_zero;
  logic [K-1:0]  quo_lo, rem_hi;

  int tests = 0;
  int fails = 0;
  logic finished = 1'b0;

  always #10 clk = ~clk;

  div_restoring_seq #(.K(K)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quo_lo(quo_lo), .rem_hi(rem_hi), .overflow(overflow), .div_zero(div_zero)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference model: returns {dz, ovf, rem, quo}
  function automatic logic [2*K+1:0] model(input logic [DW-1:0] a, input logic [K-1:0] b, input logic sm);
    longint av, bv, am, bm, qm, rm, qs, rs;
    logic [K-1:0] q, r;
    av = sm ? longint'($signed(a)) : longint'(a);
    bv = sm ? longint'($signed(b)) : longint'(b);
    if (bv == 0) return {1'b1, 1'b0, a[K-1:0], {K{1'b1}}};
    am = (av < 0) ? -av : av;
    bm = (bv < 0) ? -bv : bv;
    if ((am >> K) >= bm) return {1'b0, 1'b1, {K{1'b0}}, {K{1'b1}}};
    qm = am / bm;
    rm = am % bm;
    qs = ((av < 0) != (bv < 0)) ? -qm : qm;
    rs = (av < 0) ? -rm : rm;
    q = K'(qs);
    r = K'(rs);
    return {1'b0, 1'b0, r, q};
  endfunction

  // issue a request, count cycles to done, check outputs and latency
  task automatic run(input logic [DW-1:0] a, input logic [K-1:0] b, input logic sm,
                     input bit poke, input string req);
    logic [2*K+1:0] e;
    int n;
    int busy_cnt;
    int exp_lat;
    e = model(a, b, sm);
    @(negedge clk);
    dividend = a; divisor = b; signed_mode = sm; start = 1'b1;
    n = 0; busy_cnt = 0;
    while (n < 40) begin
      @(negedge clk);
      n++;
      start = 1'b0;
      if (poke && n == 2) begin // R9 interfering request
        start = 1'b1; dividend = ~a; divisor = b ^ 4'b0110; signed_mode = ~sm;
      end
      if (busy) busy_cnt++;
      if (done) break;
    end
    start = 1'b0;
    exp_lat = (e[2*K+1] || e[2*K]) ? 1 : (sm ? K + 2 : K + 1);
    check(req, "latency", n, exp_lat);
    check((e[2*K+1] || e[2*K]) ? "R8" : (sm ? "R7" : "R6"), "busy cycles",
          busy_cnt, exp_lat - 1);
    check(req, "quotient", quo_lo, e[K-1:0]);
    check(req, "remainder", rem_hi, e[2*K-1:K]);
    check("R4", "div_zero", div_zero, e[2*K+1]);
    check("R5", "overflow", overflow, e[2*K]);
    @(negedge clk);
    check("R10", "done one cycle", done, 0);
    dividend = ~dividend;
    @(negedge clk);
    check("R10", "quotient held", quo_lo, e[K-1:0]);
  endtask

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    #1;
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "quotient", quo_lo, 0);
    check("R1", "remainder", rem_hi, 0);
    check("R1", "flags", {overflow, div_zero}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    run(8'h75, 4'hA, 1'b0, 0, "R2");
    run(8'h0D, 4'h5, 1'b0, 0, "R2");
    run(8'd5, 4'hD, 1'b1, 0, "R3");     // 5 / -3
    run(8'hFB, 4'h3, 1'b1, 0, "R3");    // -5 / 3
    run(8'hFB, 4'hD, 1'b1, 0, "R3");    // -5 / -3
    run(8'h80, 4'h8, 1'b1, 0, "R5");    // most negative operands
    run(8'h37, 4'h0, 1'b0, 0, "R4");
    run(8'hC9, 4'h0, 1'b1, 0, "R4");
    run(8'hA0, 4'h9, 1'b0, 0, "R5");
    run(8'h75, 4'hA, 1'b0, 1, "R9");
    run(8'hF9, 4'h5, 1'b1, 1, "R9");

    for (int i = 0; i < 300; i++) begin
      logic [DW-1:0] a;
      logic [K-1:0] b;
      logic sm;
      a  = DW'($urandom);
      b  = K'($urandom);
      sm = 1'($urandom);
      if (($urandom % 4) != 0) a[DW-1:K] = a[DW-1:K] & (b >> 1);
      run(a, b, sm, ($urandom % 8) == 0, sm ? "R3" : "R2");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule